// File: doc/BRIEF.md
# Byte-Granular Concatenate-and-Shift Aligner

This SIMD datapath unit joins two packed operands into a composite twice as wide as the operand. It shifts that composite right by a whole number of bytes and returns the low half as the result. The first operand always supplies the upper half of the composite and the second operand the lower half. The 8-bit shift count is unsigned and is read in bytes. Bytes shifted in from above are zero, so a count at or past twice the operand width in bytes leaves nothing but zeros.

A 2-bit mode input selects the operand width and what happens to the unused upper result bits:

- **Half-lane mode** works on operands half a lane wide.
- **Keep mode** works on one lane and carries the first operand's upper bits through as the old destination value.
- **Clear mode** works on one lane and zeroes everything above it.
- **Dual mode** runs every lane side by side with one shared count, and no byte moves from one lane to another.

The result is registered, so a request at the input produces a result one cycle later, with a matching valid flag.

Top module: `byte_align_unit`

## Requirements
- R1: In modes 01, 10 and 11, result byte k of lane 0 (0 <= k < LANE_BYTES) equals composite byte k+count. Composite bytes 0..LANE_BYTES-1 are opb_i lane 0 bytes and composite bytes LANE_BYTES..2*LANE_BYTES-1 are opa_i lane 0 bytes. Any composite index at or above 2*LANE_BYTES reads as zero.
- R2: Any count from 2*LANE_BYTES up to 255 gives an all-zero lane in modes 01, 10 and 11, because the count is treated as unsigned.
- R3: In mode 00, result byte k (k < LANE_BYTES/2) equals byte k+count of the composite built from the low LANE_BYTES/2 bytes of opa_i (upper) and opb_i (lower). The result is zero once count >= LANE_BYTES.
- R4: In mode 00, all result bits from LANE_BYTES*4 upward are zero.
- R5: In mode 01, result bits above lane 0 equal the same bits of opa_i.
- R6: In mode 10, result bits above lane 0 are zero.
- R7: In mode 11, each upper lane is computed as in R1 from the same lane of opa_i and opb_i with the same count, and no bytes cross between lanes.
- R8: valid_o equals valid_i one clock earlier, and res_o carries the result of the input presented with that valid.
- R9: While valid_i is low, res_o holds its last value.
- R10: A synchronous active-high rst clears valid_o and res_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request valid |
| mode_i | input | 2 | 00 half-lane, 01 keep upper, 10 clear upper, 11 dual lane |
| count_i | input | 8 | Unsigned byte shift count |
| opa_i | input | LANES*LANE_BYTES*8 | First operand, upper composite half, old destination |
| opb_i | input | LANES*LANE_BYTES*8 | Second operand, lower composite half |
| valid_o | output | 1 | Result valid |
| res_o | output | LANES*LANE_BYTES*8 | Registered result |

## Verification
The bench builds the unit with LANE_BYTES = 4 and LANES = 2, which gives a 64-bit datapath with 16-bit half-lane operands. With this size, every one of the 256 count values can be swept in all four modes over several random operand pairs within a few thousand cycles. That sweep reaches every log-shifter stage combination, both saturation thresholds (4 and 8 bytes), and the lane boundary where crossing bytes would show. Hold, valid timing and a reset during traffic are checked separately at the ports.

// File: rtl/byte_align_pkg.sv
`timescale 1ns/1ps
package byte_align_pkg;
  typedef enum logic [1:0] {
    MODE_HALF  = 2'b00,
    MODE_KEEP  = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_DUAL  = 2'b11
  } align_mode_e;
endpackage

// File: rtl/byte_log_shifter.sv
`timescale 1ns/1ps
module byte_log_shifter #(
  parameter int OP_BYTES = 16
) (
  input  logic [2*OP_BYTES*8-1:0] comp_i,
  input  logic [7:0]              cnt_i,
  output logic [OP_BYTES*8-1:0]   res_o
);
  localparam int CW = 2 * OP_BYTES * 8;
  localparam int OW = OP_BYTES * 8;
  localparam int SB = $clog2(2 * OP_BYTES);

  logic [CW-1:0] stg [0:SB-1];
  logic [OW-1:0] last;
  logic          sat;

  assign stg[0] = comp_i;

  generate
    for (genvar s = 0; s < SB - 1; s++) begin : g_stage
      localparam int SH = 8 * (2 ** s);
      assign stg[s+1] = cnt_i[s] ? (stg[s] >> SH) : stg[s];
    end
    if (SB < 8) begin : g_sat
      assign sat = |cnt_i[7:SB];
    end else begin : g_nosat
      assign sat = 1'b0;
    end
  endgenerate

  // final stage moves by exactly half the composite, so only a select is needed
  assign last  = cnt_i[SB-1] ? stg[SB-1][CW-1:OW] : stg[SB-1][OW-1:0];
  assign res_o = sat ? '0 : last;

  always_comb begin
    AST_SAT_ZERO: assert (int'(cnt_i) < 2 * OP_BYTES || res_o == '0); // R2
  end
endmodule

// File: rtl/byte_align_lane.sv
`timescale 1ns/1ps
module byte_align_lane #(
  parameter int OP_BYTES = 16
) (
  input  logic [OP_BYTES*8-1:0] hi_i,
  input  logic [OP_BYTES*8-1:0] lo_i,
  input  logic [7:0]            cnt_i,
  output logic [OP_BYTES*8-1:0] res_o
);
  logic [2*OP_BYTES*8-1:0] comp;

  assign comp = {hi_i, lo_i};

  byte_log_shifter #(.OP_BYTES(OP_BYTES)) i_shift (
    .comp_i (comp),
    .cnt_i  (cnt_i),
    .res_o  (res_o)
  );

  always_comb begin
    AST_ZERO_COUNT_PASS: assert (cnt_i != 8'd0 || res_o == lo_i); // R1
  end
endmodule

// File: rtl/byte_align_unit.sv
`timescale 1ns/1ps
module byte_align_unit
  import byte_align_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int LANES      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          valid_i,
  input  logic [1:0]                    mode_i,
  input  logic [7:0]                    count_i,
  input  logic [LANES*LANE_BYTES*8-1:0] opa_i,
  input  logic [LANES*LANE_BYTES*8-1:0] opb_i,
  output logic                          valid_o,
  output logic [LANES*LANE_BYTES*8-1:0] res_o
);
  localparam int LANE_W     = LANE_BYTES * 8;
  localparam int W          = LANES * LANE_W;
  localparam int HALF_BYTES = LANE_BYTES / 2;
  localparam int HALF_W     = HALF_BYTES * 8;

  logic [LANE_W-1:0] lane_res [0:LANES-1];
  logic [HALF_W-1:0] half_res;
  logic [W-1:0]      dual_res;
  logic [W-1:0]      nxt;
  logic [W-1:0]      res_q;
  logic              valid_q;
  align_mode_e       mode;

  assign mode = align_mode_e'(mode_i);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      byte_align_lane #(.OP_BYTES(LANE_BYTES)) i_lane (
        .hi_i  (opa_i[l*LANE_W +: LANE_W]),
        .lo_i  (opb_i[l*LANE_W +: LANE_W]),
        .cnt_i (count_i),
        .res_o (lane_res[l])
      );
      assign dual_res[l*LANE_W +: LANE_W] = lane_res[l];
    end
  endgenerate

  byte_align_lane #(.OP_BYTES(HALF_BYTES)) i_half (
    .hi_i  (opa_i[HALF_W-1:0]),
    .lo_i  (opb_i[HALF_W-1:0]),
    .cnt_i (count_i),
    .res_o (half_res)
  );

  always_comb begin
    nxt = '0;
    unique case (mode)
      MODE_HALF:  nxt[HALF_W-1:0] = half_res;
      MODE_KEEP:  nxt = {opa_i[W-1:LANE_W], lane_res[0]};
      MODE_CLEAR: nxt[LANE_W-1:0] = lane_res[0];
      MODE_DUAL:  nxt = dual_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= nxt;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o)); // R9
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 2'b00) |=> res_o[W-1:HALF_W] == '0); // R4
  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 2'b01) |=> res_o[W-1:LANE_W] == $past(opa_i[W-1:LANE_W])); // R5
  AST_CLEAR_UPPER: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 2'b10) |=> res_o[W-1:LANE_W] == '0); // R6
  AST_DUAL_SAT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 2'b11 && int'(count_i) >= 2 * LANE_BYTES) |=> res_o == '0); // R2
endmodule

// File: tb/test_byte_align_unit.sv
`timescale 1ns/1ps
module test_byte_align_unit;
  localparam int LB    = 4;
  localparam int LN    = 2;
  localparam int LW    = LB * 8;
  localparam int W     = LN * LW;
  localparam int HB    = LB / 2;
  localparam int HW    = HB * 8;
  localparam int NPAT  = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [7:0]   count_i = 8'd0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         valid_o;
  logic [W-1:0] res_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  byte_align_unit #(.LANE_BYTES(LB), .LANES(LN)) i_byte_align_unit (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .count_i (count_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .valid_o (valid_o),
    .res_o   (res_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // byte k of a lane result: composite index k+cnt, lower part from b, upper part from a
  function automatic logic [7:0] pick(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input int base, input int nb, input int cnt, input int k);
    int idx;
    idx = k + cnt;
    if (idx < nb) return b[(base + idx) * 8 +: 8];
    else if (idx < 2 * nb) return a[(base + idx - nb) * 8 +: 8];
    else return 8'h00;
  endfunction

  function automatic logic [W-1:0] lane_exp(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input int lane, input int cnt);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < LB; k++) r[k*8 +: 8] = pick(a, b, lane * LB, LB, cnt, k);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] r;
    for (int i = 0; i < W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic run_vec(input logic [1:0] m, input int cnt, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] e;
    logic [W-1:0] act;
    valid_i = 1'b1;
    mode_i  = m;
    count_i = cnt[7:0];
    opa_i   = a;
    opb_i   = b;
    @(negedge clk);
    chk(valid_o === 1'b1, "R8 valid", {{(W-1){1'b0}}, valid_o}, {{(W-1){1'b0}}, 1'b1});
    if (m == 2'b00) begin
      e = '0;
      for (int k = 0; k < HB; k++) e[k*8 +: 8] = pick(a, b, 0, HB, cnt, k);
      act = '0; act[HW-1:0] = res_o[HW-1:0];
      chk(act === e, "R3 half-lane", act, e);
      act = '0; act[W-1:HW] = res_o[W-1:HW];
      chk(act === '0, "R4 half upper", act, '0);
    end else begin
      e = lane_exp(a, b, 0, cnt);
      act = '0; act[LW-1:0] = res_o[LW-1:0];
      if (cnt >= 2 * LB) chk(act === e && e === '0, "R2 saturate", act, e);
      else chk(act === e, "R1 lane0", act, e);
      act = '0; act[W-1:LW] = res_o[W-1:LW];
      if (m == 2'b01) begin
        e = '0; e[W-1:LW] = a[W-1:LW];
        chk(act === e, "R5 keep upper", act, e);
      end else if (m == 2'b10) begin
        chk(act === '0, "R6 clear upper", act, '0);
      end else begin
        e = '0;
        for (int l = 1; l < LN; l++) e[l*LW +: LW] = lane_exp(a, b, l, cnt)[LW-1:0];
        chk(act === e, "R7 upper lane", act, e);
      end
    end
  endtask

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] a;
    logic [W-1:0] b;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0, "R10 reset valid", {{(W-1){1'b0}}, valid_o}, '0);
    chk(res_o === '0, "R10 reset result", res_o, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o === 1'b0, "R8 idle valid", {{(W-1){1'b0}}, valid_o}, '0);

    for (int p = 0; p < NPAT; p++) begin
      a = rnd_word();
      b = rnd_word();
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 256; c++)
          run_vec(m[1:0], c, a, b);
    end

    // hold: a known result, then idle cycles with new data at the inputs
    run_vec(2'b11, 1, rnd_word(), rnd_word());
    held = res_o;
    valid_i = 1'b0;
    opa_i = ~opa_i;
    opb_i = ~opb_i;
    count_i = 8'd3;
    repeat (3) @(negedge clk);
    chk(res_o === held, "R9 hold", res_o, held);
    chk(valid_o === 1'b0, "R8 drop", {{(W-1){1'b0}}, valid_o}, '0);

    // reset during traffic
    run_vec(2'b01, 2, rnd_word(), rnd_word());
    rst = 1'b1;
    valid_i = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0, "R10 mid reset valid", {{(W-1){1'b0}}, valid_o}, '0);
    chk(res_o === '0, "R10 mid reset result", res_o, '0);
    rst = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule